// File: doc/BRIEF.md
# Transceiver Reset Sequencing Controller

This block steps one serial transceiver channel through its reset and power-down controls for a PCIe-style link. After a global reset it runs an initialization and compliance sequence. The PLL is held powered down for a minimum time, then the transmit side is released once its PLL locks. The receiver analog reset is released once the channel is no longer busy, and the receiver digital reset is released when the receive PLL reports lock to its reference clock. In this phase the frequency-lock indication plays no part.

When the link layer signals that compliance has finished, the controller moves to its normal phase. There, a drop of receive frequency lock starts a recovery sequence. The controller waits for lock to reference, then for frequency lock to return, then for a fixed hold-off of at least 4 µs. It then pulses the receiver digital reset for two cycles to initialize the receive phase-compensation FIFO. A data-valid qualifier tells downstream logic when received data may be used. Lock and busy inputs arrive asynchronously and pass through two-flop synchronizers. All controls are plain level signals, so no valid/ready handshake or back-pressure applies. The current state is exposed for debug.

Top module: `xrs_top`

## Requirements
- R1: While the global reset is asserted, and for at least ceil(CLK_FREQ_HZ × 1 µs) cycles after it is released (250 cycles at the default 250 MHz), the controller holds PLL power-down, TX digital reset, RX analog reset and RX digital reset all high in state code 0.
- R2: After power-down ends (state code 1), TX digital reset stays high until the synchronized TX PLL lock input is high. The controller then releases it and enters state code 2.
- R3: In state code 2, RX analog reset stays high while busy is high. It is released, entering state code 3, only after busy has gone low.
- R4: In state code 3, RX digital reset is released, entering compliance state code 4, when the lock-to-reference input is high. Rises and falls of the frequency-lock input have no effect in states 3 and 4.
- R5: The compliance-done input moves the controller from state code 4 to normal state code 5. In any earlier state it is ignored.
- R6: In normal state 5, a falling edge of frequency lock enters state code 6. Code 6 waits for lock to reference, then moves to code 7. Code 7 waits for frequency lock, then moves to hold-off code 8. Loss of lock to reference alone in state 5 has no effect.
- R7: The hold-off lasts at least ceil(CLK_FREQ_HZ × 4 µs) cycles after frequency lock returns. RX digital reset is then high for exactly two cycles in state code 9, after which the controller returns to state code 5.
- R8: The data-valid output is high only in states 4 and 5. It is low from the frequency-lock drop until RX digital reset falls at the end of the pulse.
- R9: Asserting the active-low global reset asynchronously forces state code 0 with all four reset controls high and data-valid low, without waiting for a clock edge.
- R10: Each lock and busy input takes effect on the state and controls no later than three clock edges after it changes, because of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous global reset, active low |
| tx_pll_lock_i | input | 1 | TX PLL lock, asynchronous |
| busy_i | input | 1 | Channel busy flag, asynchronous |
| rx_ref_lock_i | input | 1 | RX PLL locked to reference, asynchronous |
| rx_freq_lock_i | input | 1 | RX frequency lock, asynchronous |
| compliance_done_i | input | 1 | Link layer finished compliance, synchronous |
| pll_pwrdn_o | output | 1 | PLL power-down |
| tx_dig_rst_o | output | 1 | TX digital reset |
| rx_ana_rst_o | output | 1 | RX analog reset |
| rx_dig_rst_o | output | 1 | RX digital reset |
| rx_data_valid_o | output | 1 | Received data may be used |
| state_o | output | 4 | Current state code (debug) |

## Verification
The bound checker holds a set of ordering rules on every cycle. Power-down never occurs without all three resets. Each reset release is preceded by its synchronized enabling input. Data-valid never coexists with a receiver reset. Every RX digital reset pulse in recovery falls two cycles after it rises. Entry into the normal state comes only from compliance or from the recovery pulse. The minimum durations of the power-down and hold-off waits, the rule that frequency lock is ignored during compliance, the rule that compliance-done is ignored before release, and the asynchronous nature of the reset can only be shown by the bench's timed scenarios.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [3:0] {
    ST_PWRDN       = 4'd0,
    ST_TXLOCK      = 4'd1,
    ST_RXBUSY      = 4'd2,
    ST_RXREF       = 4'd3,
    ST_COMPL       = 4'd4,
    ST_NORMAL      = 4'd5,
    ST_RELOCK_REF  = 4'd6,
    ST_RELOCK_FREQ = 4'd7,
    ST_HOLDOFF     = 4'd8,
    ST_RXD_PULSE   = 4'd9
  } xrs_state_e;

  typedef struct packed {
    logic pll_pwrdn;
    logic tx_dig;
    logic rx_ana;
    logic rx_dig;
    logic valid;
  } xrs_ctl_t;

  // Control levels owned by each state.
  function automatic xrs_ctl_t ctl_of(xrs_state_e s);
    xrs_ctl_t c;
    c = '{pll_pwrdn: 1'b0, tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b0, valid: 1'b0};
    unique case (s)
      ST_PWRDN:       c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      ST_TXLOCK:      c = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      ST_RXBUSY:      c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      ST_RXREF:       c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      ST_COMPL,
      ST_NORMAL:      c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      ST_RELOCK_REF,
      ST_RELOCK_FREQ,
      ST_HOLDOFF:     c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      ST_RXD_PULSE:   c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      default:        c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    endcase
    return c;
  endfunction

  // Cycles covering at least the given time, rounded up.
  function automatic int cycles_for_ns(longint unsigned hz, longint unsigned ns);
    longint unsigned n;
    n = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (n < 1) n = 1;
    return int'(n);
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg[g] <= '0;
      else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
  parameter int LIMIT = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
  import xrs_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tx_lock_i,
  input  logic       busy_i,
  input  logic       ref_lock_i,
  input  logic       freq_lock_i,
  input  logic       cdone_i,
  input  logic       pwrdn_done_i,
  input  logic       hold_done_i,
  input  logic       pulse_done_i,
  output xrs_state_e state_o,
  output xrs_ctl_t   ctl_o
);

  xrs_state_e state_q, state_d;
  logic       freq_prev_q;
  xrs_ctl_t   ctl_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRDN:       if (pwrdn_done_i) state_d = ST_TXLOCK;
      ST_TXLOCK:      if (tx_lock_i)    state_d = ST_RXBUSY;
      ST_RXBUSY:      if (!busy_i)      state_d = ST_RXREF;
      ST_RXREF:       if (ref_lock_i)   state_d = ST_COMPL;
      ST_COMPL:       if (cdone_i)      state_d = ST_NORMAL;
      ST_NORMAL:      if (freq_prev_q && !freq_lock_i) state_d = ST_RELOCK_REF;
      ST_RELOCK_REF:  if (ref_lock_i)   state_d = ST_RELOCK_FREQ;
      ST_RELOCK_FREQ: if (freq_lock_i)  state_d = ST_HOLDOFF;
      ST_HOLDOFF:     if (hold_done_i)  state_d = ST_RXD_PULSE;
      ST_RXD_PULSE:   if (pulse_done_i) state_d = ST_NORMAL;
      default:                          state_d = ST_PWRDN;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q     <= ST_PWRDN;
      ctl_q       <= ctl_of(ST_PWRDN);
      freq_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      ctl_q       <= ctl_of(state_d);
      freq_prev_q <= freq_lock_i;
    end
  end

  assign state_o = state_q;
  assign ctl_o   = ctl_q;

endmodule

// File: rtl/xrs_top.sv
module xrs_top
  import xrs_pkg::*;
#(
  parameter int CLK_FREQ_HZ  = 250_000_000,
  parameter int PWRDN_NS     = 1000,
  parameter int HOLDOFF_NS   = 4000,
  parameter int PULSE_CYC    = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tx_pll_lock_i,
  input  logic       busy_i,
  input  logic       rx_ref_lock_i,
  input  logic       rx_freq_lock_i,
  input  logic       compliance_done_i,
  output logic       pll_pwrdn_o,
  output logic       tx_dig_rst_o,
  output logic       rx_ana_rst_o,
  output logic       rx_dig_rst_o,
  output logic       rx_data_valid_o,
  output logic [3:0] state_o
);

  localparam int PWRDN_CYC = cycles_for_ns(longint'(CLK_FREQ_HZ), longint'(PWRDN_NS));
  localparam int HOLD_CYC  = cycles_for_ns(longint'(CLK_FREQ_HZ), longint'(HOLDOFF_NS));
  localparam int N_TMR     = 3;
  localparam int TMR_LIM [N_TMR] = '{PWRDN_CYC, HOLD_CYC, PULSE_CYC};

  logic [3:0] async_in, sync_out;
  logic       tx_lock_s, busy_s, ref_s, freq_s;

  assign async_in = {tx_pll_lock_i, busy_i, rx_ref_lock_i, rx_freq_lock_i};
  assign {tx_lock_s, busy_s, ref_s, freq_s} = sync_out;

  xrs_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_i(async_in), .q_o(sync_out)
  );

  xrs_state_e state;
  xrs_ctl_t   ctl;
  logic [N_TMR-1:0] tmr_run, tmr_done;

  assign tmr_run = {state == ST_RXD_PULSE, state == ST_HOLDOFF, state == ST_PWRDN};

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    xrs_timer #(.LIMIT(TMR_LIM[g])) u_tmr (
      .clk(clk), .arst_n(arst_n), .run_i(tmr_run[g]), .done_o(tmr_done[g])
    );
  end

  xrs_fsm u_fsm (
    .clk(clk), .arst_n(arst_n),
    .tx_lock_i(tx_lock_s), .busy_i(busy_s), .ref_lock_i(ref_s), .freq_lock_i(freq_s),
    .cdone_i(compliance_done_i),
    .pwrdn_done_i(tmr_done[0]), .hold_done_i(tmr_done[1]), .pulse_done_i(tmr_done[2]),
    .state_o(state), .ctl_o(ctl)
  );

  assign pll_pwrdn_o     = ctl.pll_pwrdn;
  assign tx_dig_rst_o    = ctl.tx_dig;
  assign rx_ana_rst_o    = ctl.rx_ana;
  assign rx_dig_rst_o    = ctl.rx_dig;
  assign rx_data_valid_o = ctl.valid;
  assign state_o         = state;

endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
  input logic       clk,
  input logic       arst_n,
  input logic [3:0] state_o,
  input logic       pll_pwrdn_o,
  input logic       tx_dig_rst_o,
  input logic       rx_ana_rst_o,
  input logic       rx_dig_rst_o,
  input logic       rx_data_valid_o,
  input logic       tx_lock_s,
  input logic       busy_s,
  input logic       ref_s
);

  assert_pwrdn_holds_resets_R1: assert property (@(posedge clk) disable iff (!arst_n)
    pll_pwrdn_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

  assert_tx_release_after_lock_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(tx_dig_rst_o) |-> $past(tx_lock_s));

  assert_rx_ana_release_not_busy_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rx_ana_rst_o) |-> !$past(busy_s));

  assert_compl_release_on_ref_R4: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(rx_dig_rst_o) && state_o == 4'd4) |-> $past(ref_s));

  assert_normal_entry_order_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (state_o == 4'd5 && $past(state_o) != 4'd5) |-> ($past(state_o) == 4'd4 || $past(state_o) == 4'd9));

  assert_relock_after_ref_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (state_o == 4'd7 && $past(state_o) == 4'd6) |-> $past(ref_s));

  assert_pulse_two_cycles_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rx_dig_rst_o) |-> ##2 !rx_dig_rst_o);

  assert_valid_excludes_reset_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rx_data_valid_o |-> (!rx_dig_rst_o && !rx_ana_rst_o && !pll_pwrdn_o));

endmodule

bind xrs_top xrs_checker u_chk (
  .clk(clk), .arst_n(arst_n), .state_o(state_o),
  .pll_pwrdn_o(pll_pwrdn_o), .tx_dig_rst_o(tx_dig_rst_o),
  .rx_ana_rst_o(rx_ana_rst_o), .rx_dig_rst_o(rx_dig_rst_o),
  .rx_data_valid_o(rx_data_valid_o),
  .tx_lock_s(tx_lock_s), .busy_s(busy_s), .ref_s(ref_s)
);

// File: tb/test_xrs_top.sv
`timescale 1ns/1ps
module test_xrs_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic arst_n, tx_lock, busy, ref_lock, freq_lock, cdone;
  logic pll_pwrdn, tx_dig, rx_ana, rx_dig, valid;
  logic [3:0] state;

  xrs_top i_xrs_top (
    .clk(clk), .arst_n(arst_n),
    .tx_pll_lock_i(tx_lock), .busy_i(busy), .rx_ref_lock_i(ref_lock),
    .rx_freq_lock_i(freq_lock), .compliance_done_i(cdone),
    .pll_pwrdn_o(pll_pwrdn), .tx_dig_rst_o(tx_dig), .rx_ana_rst_o(rx_ana),
    .rx_dig_rst_o(rx_dig), .rx_data_valid_o(valid), .state_o(state)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int outs();
    return int'({pll_pwrdn, tx_dig, rx_ana, rx_dig, valid});
  endfunction

  // {tx,busy,ref,freq,cdone} , expected state , expected {pwrdn,txd,rxa,rxd,valid}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {5'b01000, 4'd1, 5'b01110},
    {5'b11000, 4'd2, 5'b00110},
    {5'b10000, 4'd3, 5'b00010},
    {5'b10001, 4'd3, 5'b00010},
    {5'b10010, 4'd3, 5'b00010},
    {5'b10100, 4'd4, 5'b00001},
    {5'b10110, 4'd4, 5'b00001},
    {5'b10100, 4'd4, 5'b00001},
    {5'b10101, 4'd5, 5'b00001},
    {5'b10110, 4'd5, 5'b00001},
    {5'b10010, 4'd5, 5'b00001},
    {5'b10000, 4'd6, 5'b00000},
    {5'b10010, 4'd6, 5'b00000},
    {5'b10100, 4'd7, 5'b00000}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R5";
      4, 5, 6, 7: return "R4";
      8, 9: return "R5";
      10, 11, 12, 13: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin : watchdog
    #(4 * 200_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int cnt;
    arst_n = 1'b0; tx_lock = 1'b0; busy = 1'b1; ref_lock = 1'b0; freq_lock = 1'b0; cdone = 1'b0;
    repeat (4) @(negedge clk);
    // R1 / R9: reset state
    check("R1 reset state", int'(state), 0);
    check("R1 reset outputs", outs(), 5'b11110);

    arst_n = 1'b1;
    cnt = 0;
    while (pll_pwrdn && cnt < 2000) begin
      if (cnt == 100) check("R1 resets held during power-down", outs(), 5'b11110);
      @(negedge clk);
      cnt++;
    end
    check_range("R1 power-down length", cnt, 250, 252);

    // R2: TX reset stays while TX lock low
    repeat (300) @(negedge clk);
    check("R2 tx reset held without lock", int'(tx_dig), 1);

    for (int i = 0; i < NV; i++) begin
      {tx_lock, busy, ref_lock, freq_lock, cdone} = VEC[i][13:9];
      repeat (5) @(posedge clk);
      @(negedge clk);
      check({tag_of(i), " state"}, int'(state), int'(VEC[i][8:5]));
      check({tag_of(i), " outputs"}, outs(), int'(VEC[i][4:0]));
    end

    // R7 / R8: frequency lock returns, hold-off, pulse
    freq_lock = 1'b1;
    cnt = 0;
    while (!rx_dig && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      if (cnt == 500) check("R8 valid low during hold-off", int'(valid), 0);
      if (cnt == 500) check("R7 hold-off state", int'(state), 8);
    end
    check_range("R7 hold-off length", cnt, 1000, 1006);
    check("R7 pulse state", int'(state), 9);
    cnt = 0;
    while (rx_dig && cnt < 50) begin
      check("R8 valid low during pulse", int'(valid), 0);
      @(negedge clk);
      cnt++;
    end
    check("R7 pulse width", cnt, 2);
    check("R7 back to normal", int'(state), 5);
    check("R8 valid after pulse", int'(valid), 1);

    // R10: synchronizer latency on a frequency drop
    ref_lock = 1'b1;
    freq_lock = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 drop seen within three edges", int'(state), 6);

    // R9: asynchronous reset mid-operation
    @(negedge clk);
    #1;
    arst_n = 1'b0;
    #0.5;
    check("R9 async state", int'(state), 0);
    check("R9 async outputs", outs(), 5'b11110);
    @(negedge clk);
    arst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule